// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes in stereo serial audio as a pure slave. A bit clock, a word-select line and a data line all arrive from outside. The block never drives any of them. It oversamples the three lines with its own system clock, which is frequency-locked to the serial stream. It finds rising bit-clock edges and rebuilds one left and one right sample in every word-select period. Each completed pair appears on two 20-bit output words, together with a single-cycle valid strobe.

Three framings are understood:
- a delayed-MSB framing (I2S), where the first data bit follows the word-select change by one bit clock;
- a left-justified framing, where the first data bit coincides with the word-select change;
- a right-justified framing of 16, 18 or 20 bits, where the sample ends on the last bit before the next word-select change.

In the general mode a 3-bit format code picks the framing. In the pin-strap mode a 2-bit select picks from a reduced set of four formats. That set has no left-justified entry, and the 3-bit code is then ignored.

Top module: `serial_audio_rx`

## Requirements
- R1: Data and word select are taken only at rising edges of `sck_i` seen through the input synchronisers. `pair_valid_o` rises only in the cycle after such an edge is detected. While `sck_i` is held, changes on `lrck_i` and `sdi_i` alter no output.
- R2: With the I2S framing, the first data bit of a word sits one bit clock after the word-select change. The first 20 bits from that point are kept, MSB first.
- R3: With the left-justified framing, the first data bit of a word is the bit taken at the first bit clock after the word-select change. The first 20 bits are kept, MSB first.
- R4: With right-justified framing of length N (16, 18 or 20), only the last N bits before the next word-select change are kept. All earlier bits in the slot are dropped.
- R5: A word shorter than 20 bits is placed at the top of the 20-bit output, with zeros below. Bits past the 20th in the I2S and left-justified framings are dropped.
- R6: `lrck_i` low marks the left slot and high marks the right slot. `pair_valid_o` pulses for exactly one cycle when a right word completes after a left word. `left_o` and `right_o` change only in that cycle. The right word completes when the next left slot begins.
- R7: In general mode (`static_mode_i` = 0), `fmt_sel_i` selects the framing: 0 = I2S, 1 = left-justified, 2 = right-justified 16, 3 = right-justified 18, 4 = right-justified 20. The codes 5 to 7 act as I2S.
- R8: In pin-strap mode (`static_mode_i` = 1), `static_sel_i` selects the framing: 00 = I2S, 01 = right-justified 16, 10 = right-justified 18, 11 = right-justified 20. `fmt_sel_i` has no effect, and the left-justified framing cannot be reached.
- R9: After reset, `left_o` and `right_o` are zero and `pair_valid_o` is low. A right slot that was already under way when reset ended is not reported as a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, frequency-locked to the serial stream |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck_i | input | 1 | Serial bit clock from the external master |
| lrck_i | input | 1 | Word select (low = left, high = right) |
| sdi_i | input | 1 | Serial data |
| static_mode_i | input | 1 | 1 = pin-strap mode, 0 = general mode |
| fmt_sel_i | input | 3 | Framing code in general mode |
| static_sel_i | input | 2 | Framing select in pin-strap mode |
| left_o | output | 20 | Last completed left sample, top-aligned |
| right_o | output | 20 | Last completed right sample, top-aligned |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is on the outputs |

## Verification
Random stereo pairs are streamed in every framing, each with a slot length picked to expose a particular error.

Slot lengths and what each one separates:
- A 32-bit I2S slot and a 24-bit left-justified slot show whether the one-bit offset is applied or missing, and whether surplus trailing bits leak into the word.
- 16-bit slots in both MSB-first framings check the zero fill of short words.
- Right-justified streams carry random filler above the sample, so a receiver that counts from the front instead of the end returns wrong data.

Mode and code checks:
- The same I2S-shaped stream is sent with an out-of-range general code.
- It is also sent in pin-strap mode with the left-justified code on `fmt_sel_i`; only an I2S decode matches there.
- All three pin-strap right-justified selects are also covered.

A stretch with the bit clock frozen while word select and data toggle must leave the outputs untouched.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_MSBJ  = 3'd1,
    FMT_LSB16 = 3'd2,
    FMT_LSB18 = 3'd3,
    FMT_LSB20 = 3'd4
  } fmt_e;

  function automatic logic is_lsb(fmt_e f);
    return (f == FMT_LSB16) || (f == FMT_LSB18) || (f == FMT_LSB20);
  endfunction

  function automatic int unsigned lsb_len(fmt_e f);
    case (f)
      FMT_LSB16: return 16;
      FMT_LSB18: return 18;
      FMT_LSB20: return 20;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/sar_input_sync.sv
module sar_input_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic lrck_i,
  input  logic sdi_i,
  output logic rst_sync_n_o,
  output logic bit_tick_o,
  output logic ws_o,
  output logic sd_o
);

  localparam int unsigned TOP = STAGES - 1;

  logic [1:0]     rst_pipe;
  logic [TOP:0]   sck_p, ws_p, sd_p;
  logic           sck_last;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n_o = rst_pipe[1];

  always_ff @(posedge clk_i or negedge rst_sync_n_o) begin
    if (!rst_sync_n_o) begin
      sck_p    <= '0;
      ws_p     <= '0;
      sd_p     <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_p    <= {sck_p[TOP-1:0], sck_i};
      ws_p     <= {ws_p[TOP-1:0],  lrck_i};
      sd_p     <= {sd_p[TOP-1:0],  sdi_i};
      sck_last <= sck_p[TOP];
    end
  end

  assign bit_tick_o = sck_p[TOP] & ~sck_last;
  assign ws_o       = ws_p[TOP];
  assign sd_o       = sd_p[TOP];

endmodule

// File: rtl/sar_fmt_decode.sv
module sar_fmt_decode
  import sar_pkg::*;
(
  input  logic       static_mode_i,
  input  logic [2:0] fmt_sel_i,
  input  logic [1:0] static_sel_i,
  output fmt_e       fmt_o
);

  always_comb begin
    fmt_o = FMT_I2S;
    if (static_mode_i) begin
      case (static_sel_i)
        2'b00:   fmt_o = FMT_I2S;
        2'b01:   fmt_o = FMT_LSB16;
        2'b10:   fmt_o = FMT_LSB18;
        default: fmt_o = FMT_LSB20;
      endcase
    end else begin
      case (fmt_sel_i)
        3'd1:    fmt_o = FMT_MSBJ;
        3'd2:    fmt_o = FMT_LSB16;
        3'd3:    fmt_o = FMT_LSB18;
        3'd4:    fmt_o = FMT_LSB20;
        default: fmt_o = FMT_I2S;
      endcase
    end
  end

endmodule

// File: rtl/sar_slot_capture.sv
module sar_slot_capture
  import sar_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ws_i,
  input  logic         sd_i,
  input  fmt_e         fmt_i,
  output logic         done_o,
  output logic         done_ch_o,
  output logic [W-1:0] word_o
);

  localparam int unsigned    CW      = $clog2(W + 1);
  localparam logic [CW-1:0]  CNT_MAX = CW'(W);
  localparam logic [CW-1:0]  TOP_IDX = CW'(W - 1);
  localparam logic [W-1:0]   ONE_W   = W'(1);

  logic          primed_q, primed_d;
  logic          aligned_q, aligned_d;
  logic          ws_d1_q, ws_d1_d;
  logic          ch_q, ch_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  msb_q, msb_d;
  logic [W-1:0]  lsb_q, lsb_d;
  logic          ch_now, boundary;

  always_comb begin
    // I2S data lags word select by one bit clock
    ch_now    = (fmt_i == FMT_I2S) ? ws_d1_q : ws_i;
    boundary  = primed_q && (ch_now != ch_q);
    primed_d  = primed_q;
    aligned_d = aligned_q;
    ws_d1_d   = ws_d1_q;
    ch_d      = ch_q;
    cnt_d     = cnt_q;
    msb_d     = msb_q;
    lsb_d     = lsb_q;
    if (tick_i) begin
      primed_d = 1'b1;
      ws_d1_d  = ws_i;
      ch_d     = ch_now;
      if (boundary) begin
        aligned_d = 1'b1;
        cnt_d     = CW'(1);
        msb_d     = sd_i ? (ONE_W << TOP_IDX) : '0;
        lsb_d     = sd_i ? ONE_W : '0;
      end else begin
        lsb_d = {lsb_q[W-2:0], sd_i};
        if (cnt_q < CNT_MAX) begin
          msb_d = msb_q | ((sd_i ? ONE_W : '0) << (TOP_IDX - cnt_q));
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q  <= 1'b0;
      aligned_q <= 1'b0;
      ws_d1_q   <= 1'b0;
      ch_q      <= 1'b0;
      cnt_q     <= '0;
      msb_q     <= '0;
      lsb_q     <= '0;
    end else begin
      primed_q  <= primed_d;
      aligned_q <= aligned_d;
      ws_d1_q   <= ws_d1_d;
      ch_q      <= ch_d;
      cnt_q     <= cnt_d;
      msb_q     <= msb_d;
      lsb_q     <= lsb_d;
    end
  end

  always_comb begin
    if (is_lsb(fmt_i)) word_o = lsb_q << (W - lsb_len(fmt_i));
    else               word_o = msb_q;
  end

  assign done_o    = tick_i & boundary & aligned_q;
  assign done_ch_o = ch_q;

endmodule

// File: rtl/sar_pair_out.sv
module sar_pair_out #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic         ch_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);

  logic [W-1:0] hold_q, hold_d, left_q, left_d, right_q, right_d;
  logic         have_q, have_d, valid_q, valid_d;

  always_comb begin
    hold_d  = hold_q;
    have_d  = have_q;
    left_d  = left_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (done_i && !ch_i) begin
      hold_d = word_i;
      have_d = 1'b1;
    end else if (done_i && ch_i && have_q) begin
      left_d  = hold_q;
      right_d = word_i;
      valid_d = 1'b1;
      have_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      have_q  <= have_d;
      left_q  <= left_d;
      right_q <= right_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                lrck_i,
  input  logic                sdi_i,
  input  logic                static_mode_i,
  input  logic [2:0]          fmt_sel_i,
  input  logic [1:0]          static_sel_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                pair_valid_o
);

  logic                rst_sync_n, bit_tick, ws_s, sd_s;
  logic                done, done_ch;
  logic [SAMPLE_W-1:0] word;
  fmt_e                fmt_eff;

  sar_input_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .lrck_i(lrck_i),
    .sdi_i(sdi_i), .rst_sync_n_o(rst_sync_n), .bit_tick_o(bit_tick),
    .ws_o(ws_s), .sd_o(sd_s)
  );

  sar_fmt_decode dec_i (
    .static_mode_i(static_mode_i), .fmt_sel_i(fmt_sel_i),
    .static_sel_i(static_sel_i), .fmt_o(fmt_eff)
  );

  sar_slot_capture #(.W(SAMPLE_W)) cap_i (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .tick_i(bit_tick), .ws_i(ws_s),
    .sd_i(sd_s), .fmt_i(fmt_eff), .done_o(done), .done_ch_o(done_ch),
    .word_o(word)
  );

  sar_pair_out #(.W(SAMPLE_W)) pair_i (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .done_i(done), .ch_i(done_ch),
    .word_i(word), .left_o(left_o), .right_o(right_o),
    .valid_o(pair_valid_o)
  );

endmodule

// File: rtl/sar_checks.sv
module sar_checks
  import sar_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick,
  input logic         valid,
  input logic [W-1:0] left,
  input logic [W-1:0] right,
  input fmt_e         fmt,
  input logic         static_mode
);

  assert_tick_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> $past(tick));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |=> !valid);

  assert_outputs_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |-> ($stable(left) && $stable(right)));

  assert_no_msbj_static_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_mode |-> (fmt != FMT_MSBJ));

  assert_lsb16_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && fmt == FMT_LSB16) |-> (left[W-17:0] == '0 && right[W-17:0] == '0));

  assert_lsb18_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && fmt == FMT_LSB18) |-> (left[W-19:0] == '0 && right[W-19:0] == '0));

endmodule

bind serial_audio_rx sar_checks #(.W(SAMPLE_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(bit_tick), .valid(pair_valid_o),
  .left(left_o), .right(right_o), .fmt(fmt_eff), .static_mode(static_mode_i)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, lrck = 1'b1, sdi = 1'b0;
  logic        st_mode = 1'b0;
  logic [2:0]  fsel = '0;
  logic [1:0]  ssel = '0;
  logic [19:0] left_o, right_o;
  logic        pair_valid_o;

  int          n_checks = 0, n_fails = 0;
  string       cur_tag = "R9";
  logic        i2s_on = 1'b0, dly = 1'b0;
  logic [19:0] exp_l[$], exp_r[$];

  always #5 clk = ~clk;

  serial_audio_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .lrck_i(lrck), .sdi_i(sdi),
    .static_mode_i(st_mode), .fmt_sel_i(fsel), .static_sel_i(ssel),
    .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o)
  );

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pair_valid_o) begin
      if (exp_l.size() == 0) begin
        check(1'b0, {cur_tag, " R6 unexpected pair"}, {left_o, right_o}, 40'h0);
      end else begin
        logic [19:0] el, er;
        el = exp_l.pop_front();
        er = exp_r.pop_front();
        check(left_o == el && right_o == er, cur_tag, {left_o, right_o}, {el, er});
      end
    end
  end

  function automatic logic [19:0] exp_word(input logic [31:0] slot, input int w,
                                           input int n);
    logic [19:0] e = '0;
    for (int k = 0; k < 20; k++) begin
      if (n == 0) begin
        if (k < w) e[19-k] = slot[w-1-k];
      end else if (k < n) begin
        e[19-k] = slot[n-1-k];
      end
    end
    return e;
  endfunction

  task automatic send_bit(input logic ws, input logic b);
    sck  = 1'b0;
    lrck = ws;
    if (i2s_on) begin
      sdi = dly;
      dly = b;
    end else begin
      sdi = b;
    end
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic ws, input logic [31:0] slot, input int w);
    for (int i = 0; i < w; i++) send_bit(ws, slot[w-1-i]);
  endtask

  task automatic frame_v(input logic [31:0] l, input logic [31:0] r, input int w,
                         input int n);
    exp_l.push_back(exp_word(l, w, n));
    exp_r.push_back(exp_word(r, w, n));
    send_slot(1'b0, l, w);
    send_slot(1'b1, r, w);
  endtask

  task automatic frame(input int w, input int n);
    frame_v($urandom, $urandom, w, n);
  endtask

  task automatic start_test(input string tag, input logic st, input logic [2:0] f,
                            input logic [1:0] s, input logic i2s);
    @(negedge clk);
    rst_n   = 1'b0;
    cur_tag = tag;
    st_mode = st;
    fsel    = f;
    ssel    = s;
    i2s_on  = i2s;
    dly     = 1'b0;
    sck     = 1'b0;
    lrck    = 1'b1;
    sdi     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(left_o == '0 && right_o == '0 && !pair_valid_o, "R9 reset state",
          {left_o, right_o}, 40'h0);
    // preroll right slot, must never be reported (R9)
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
  endtask

  task automatic end_test();
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check(exp_l.size() == 0, {cur_tag, " R6 all pairs delivered"},
          40'(exp_l.size()), 40'h0);
    exp_l.delete();
    exp_r.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [39:0] snap;
    // R2: I2S, 32-bit slots
    start_test("R2 i2s32", 1'b0, 3'd0, 2'b00, 1'b1);
    frame_v(32'hFFFF_FFFF, 32'h8000_0001, 32, 0);
    frame(32, 0);
    frame(32, 0);
    end_test();

    // R1: frozen bit clock, toggling ws and data
    cur_tag = "R1";
    snap = {left_o, right_o};
    sck = 1'b1;
    for (int i = 0; i < 30; i++) begin
      lrck = ~lrck;
      sdi  = ~sdi;
      repeat (3) @(negedge clk);
      if (pair_valid_o) check(1'b0, "R1 strobe with held sck", 40'h1, 40'h0);
    end
    check({left_o, right_o} == snap, "R1 outputs held", {left_o, right_o}, snap);

    // R5: I2S short 16-bit slots, zero fill
    start_test("R5 i2s16", 1'b0, 3'd0, 2'b00, 1'b1);
    frame_v(32'h0000_FFFF, 32'h0000_A5C3, 16, 0);
    frame(16, 0);
    end_test();

    // R3/R5: left-justified, 24-bit slots, excess dropped
    start_test("R3 msbj24", 1'b0, 3'd1, 2'b00, 1'b0);
    frame_v(32'h00FF_FFFF, 32'h0012_3456, 24, 0);
    frame(24, 0);
    frame(24, 0);
    end_test();

    // R3: left-justified, 16-bit slots
    start_test("R3 msbj16", 1'b0, 3'd1, 2'b00, 1'b0);
    frame(16, 0);
    frame(16, 0);
    end_test();

    // R4: right-justified 16 in 32-bit slots
    start_test("R4 lsb16", 1'b0, 3'd2, 2'b00, 1'b0);
    frame_v(32'hFFFF_0000, 32'h0000_FFFF, 32, 16);
    frame(32, 16);
    end_test();

    // R4: right-justified 18 in 24-bit slots
    start_test("R4 lsb18", 1'b0, 3'd3, 2'b00, 1'b0);
    frame(24, 18);
    frame(24, 18);
    end_test();

    // R4: right-justified 20 in 32-bit slots
    start_test("R4 lsb20", 1'b0, 3'd4, 2'b00, 1'b0);
    frame_v(32'hFFF0_0001, 32'h000F_FFFF, 32, 20);
    frame(32, 20);
    end_test();

    // R7: out-of-range code behaves as I2S
    start_test("R7 code6", 1'b0, 3'd6, 2'b00, 1'b1);
    frame(32, 0);
    frame(32, 0);
    end_test();

    // R8: pin-strap I2S with the left-justified code on fmt_sel (ignored)
    start_test("R8 st00", 1'b1, 3'd1, 2'b00, 1'b1);
    frame(32, 0);
    frame(32, 0);
    end_test();

    // R8: pin-strap right-justified selects
    start_test("R8 st01", 1'b1, 3'd1, 2'b01, 1'b0);
    frame(32, 16);
    end_test();
    start_test("R8 st10", 1'b1, 3'd0, 2'b10, 1'b0);
    frame(32, 18);
    end_test();
    start_test("R8 st11", 1'b1, 3'd2, 2'b11, 1'b0);
    frame(24, 20);
    end_test();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule